// File: doc/BRIEF.md
# Shared-Memory Network Interrupt Controller

This block makes the interrupt decisions for one node of a replicated shared-memory network. On the transmit side, each host write to shared memory is about to go out as a network message. The block sets or clears that message's interrupt flag. It uses a global enable, a force-all override and a per-word auxiliary control bit.

On the receive side, each incoming message passes through the block, including the node's own message when it comes back around the ring. The block decides two things for that message. First, whether the write reaches local memory: ring-own acceptance and the unchanged-data filter both apply here. Second, whether the message's word address is queued in a small interrupt address FIFO.

The host drains the FIFO through a valid/ready port. It sees a not-empty status, a sticky overflow flag and an interrupt request line. The auxiliary control RAM holds two bits per word address: bit 1 enables transmit interrupts and bit 0 enables receive interrupts. The host writes it, and both sides read it combinationally in the same cycle as the message address.

The network side cannot be back-pressured. A message is presented for one cycle with `rx_valid`, and a push into a full FIFO is dropped. On the host side, `irq_valid` is high while the FIFO holds an entry. The head entry leaves on a cycle where `irq_valid` and `irq_ready` are both high. The host may hold `irq_ready` low for as long as it likes, and the entries wait.

Top module: `shmem_irq_ctrl`

## Requirements
- R1: `tx_irq_flag` is 1 exactly when `tx_valid` is high, `net_irq_en` is high, and either `tx_force` or the transmit bit (bit 1) of the ACR entry at `tx_addr` is set; otherwise it is 0.
- R2: A received message can push its address only if `rx_force` or the receive bit (bit 0) of the ACR entry at `rx_addr` is set.
- R3: A push also requires `rx_irq` and `mask_match_en` to be high, in the same cycle as `rx_valid`.
- R4: A message with `rx_own` high is accepted (memory write and any push) only when `own_accept` is set. It may push only when `own_irq` is also set. Messages with `rx_own` low are always accepted.
- R5: `rx_mem_we` is high for an accepted message unless `filter_en` and `rx_same` are both high. A message with `rx_irq` high is never suppressed by the filter.
- R6: The FIFO keeps up to DEPTH (16) addresses in arrival order. `irq_valid` is high while it is non-empty, and `irq_addr` shows the oldest entry. A pushed address becomes visible on the cycle after the push.
- R7: A pop happens on a clock edge where `irq_valid` and `irq_ready` are both high. While the FIFO is empty, `irq_addr` reads 0 and `irq_ready` has no effect.
- R8: A push into a full FIFO with no pop in the same cycle is dropped and sets `irq_overflow` on the next cycle. A pop in the same cycle makes room, and the push is kept. `ovf_clear` clears the flag, but a new drop in the same cycle wins.
- R9: `host_irq` is high exactly when the FIFO is non-empty and `net_irq_en` is high.
- R10: An ACR write with `acr_wr_en` takes effect from the next cycle. Reset clears every ACR entry to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| net_irq_en | input | 1 | Global network interrupt enable |
| tx_force | input | 1 | Transmit override: every word may send interrupts |
| rx_force | input | 1 | Receive override: every word may take interrupts |
| mask_match_en | input | 1 | Interrupt mask match enable |
| own_accept | input | 1 | Accept this node's own looped-back message |
| own_irq | input | 1 | Allow own looped-back message to interrupt |
| filter_en | input | 1 | Unchanged-data filter enable |
| acr_wr_en | input | 1 | ACR RAM write strobe |
| acr_wr_addr | input | AW | ACR word address to write |
| acr_wr_data | input | 2 | ACR entry: bit 1 transmit enable, bit 0 receive enable |
| tx_valid | input | 1 | Host write going out this cycle |
| tx_addr | input | AW | Word address of host write |
| tx_irq_flag | output | 1 | Interrupt flag for the outgoing message |
| rx_valid | input | 1 | Incoming message this cycle |
| rx_addr | input | AW | Word address of incoming message |
| rx_irq | input | 1 | Interrupt flag of incoming message |
| rx_own | input | 1 | Message originated at this node |
| rx_same | input | 1 | Incoming data equals the stored data |
| rx_mem_we | output | 1 | Write incoming data into local memory |
| irq_valid | output | 1 | FIFO not empty |
| irq_ready | input | 1 | Host takes the head entry |
| irq_addr | output | AW | Head address, 0 when empty |
| irq_overflow | output | 1 | Sticky: a push was dropped |
| ovf_clear | input | 1 | Write-1 clear of the overflow flag |
| host_irq | output | 1 | Interrupt request to the host |

## Verification
The assertions cover the rules that hold on every cycle. A transmit flag never appears without the global enable. No push happens without mask match and a set flag. An own message is never accepted without `own_accept`, and an interrupt message always reaches memory. The FIFO count never passes its depth and an empty FIFO reads zero. A drop always raises the overflow flag, and an ACR write always lands. Only the bench's scenarios can show the rest. It sweeps every combination of the control bits against the receive and transmit rules. It checks arrival order across a full FIFO and the exact cycle a drop sets the flag. It also covers a push and a pop together while full, a clear colliding with nothing, and the all-zero ACR contents after reset.

// File: rtl/shmem_irq_pkg.sv
package shmem_irq_pkg;
  typedef struct packed {
    logic tx_en;
    logic rx_en;
  } acr_t;
endpackage

// File: rtl/acr_ram.sv
module acr_ram
  import shmem_irq_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  acr_t          wr_data,
  input  logic [AW-1:0] tx_raddr,
  output acr_t          tx_entry,
  input  logic [AW-1:0] rx_raddr,
  output acr_t          rx_entry
);
  localparam int WORDS = 1 << AW;

  acr_t mem [WORDS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  assign tx_entry = mem[tx_raddr];
  assign rx_entry = mem[rx_raddr];

  p_write_lands_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> mem[$past(wr_addr)] == $past(wr_data));
endmodule

// File: rtl/irq_decide.sv
module irq_decide
  import shmem_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic net_irq_en,
  input  logic tx_force,
  input  logic rx_force,
  input  logic mask_match_en,
  input  logic own_accept,
  input  logic own_irq,
  input  logic filter_en,
  input  logic tx_valid,
  input  acr_t tx_entry,
  input  logic rx_valid,
  input  acr_t rx_entry,
  input  logic rx_irq,
  input  logic rx_own,
  input  logic rx_same,
  output logic tx_irq_flag,
  output logic rx_mem_we,
  output logic rx_push
);
  logic accepted, eligible, own_ok;

  always_comb begin
    tx_irq_flag = tx_valid && net_irq_en && (tx_force || tx_entry.tx_en);
    accepted    = rx_valid && (!rx_own || own_accept);
    own_ok      = !rx_own || own_irq;
    eligible    = rx_force || rx_entry.rx_en;
    rx_push     = accepted && rx_irq && eligible && mask_match_en && own_ok;
    rx_mem_we   = accepted && !(filter_en && rx_same && !rx_irq);
  end

  p_tx_needs_enable_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq_flag |-> net_irq_en && tx_valid);
  p_push_needs_eligible_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> rx_force || rx_entry.rx_en);
  p_push_needs_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> mask_match_en && rx_irq && rx_valid);
  p_own_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_own && !own_accept) |-> !rx_push && !rx_mem_we);
  p_irq_bypass_filter_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_irq && (!rx_own || own_accept)) |-> rx_mem_we);
endmodule

// File: rtl/irq_addr_fifo.sv
module irq_addr_fifo #(
  parameter int W     = 6,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop_ready,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  output logic         drop
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [W-1:0]  store [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          do_pop, do_push, full;

  always_comb begin
    full      = (count == FULL);
    out_valid = (count != '0);
    do_pop    = out_valid && pop_ready;
    do_push   = push && (!full || do_pop);
    drop      = push && full && !do_pop;
    out_data  = out_valid ? store[rd_ptr] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) begin
        store[wr_ptr] <= push_data;
        wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      end
      if (do_pop) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      if (do_push && !do_pop)      count <= count + 1'b1;
      else if (do_pop && !do_push) count <= count - 1'b1;
    end
  end

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL);
  p_empty_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && pop_ready && !push) |=> !out_valid);
  p_empty_reads_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> out_data == '0);
endmodule

// File: rtl/shmem_irq_ctrl.sv
module shmem_irq_ctrl
  import shmem_irq_pkg::*;
#(
  parameter int AW    = 6,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          net_irq_en,
  input  logic          tx_force,
  input  logic          rx_force,
  input  logic          mask_match_en,
  input  logic          own_accept,
  input  logic          own_irq,
  input  logic          filter_en,
  input  logic          acr_wr_en,
  input  logic [AW-1:0] acr_wr_addr,
  input  logic [1:0]    acr_wr_data,
  input  logic          tx_valid,
  input  logic [AW-1:0] tx_addr,
  output logic          tx_irq_flag,
  input  logic          rx_valid,
  input  logic [AW-1:0] rx_addr,
  input  logic          rx_irq,
  input  logic          rx_own,
  input  logic          rx_same,
  output logic          rx_mem_we,
  output logic          irq_valid,
  input  logic          irq_ready,
  output logic [AW-1:0] irq_addr,
  output logic          irq_overflow,
  input  logic          ovf_clear,
  output logic          host_irq
);
  acr_t tx_entry, rx_entry;
  logic rx_push, drop;

  acr_ram #(.AW(AW)) u_acr (
    .clk(clk), .rst_n(rst_n),
    .wr_en(acr_wr_en), .wr_addr(acr_wr_addr), .wr_data(acr_t'(acr_wr_data)),
    .tx_raddr(tx_addr), .tx_entry(tx_entry),
    .rx_raddr(rx_addr), .rx_entry(rx_entry)
  );

  irq_decide u_dec (
    .clk(clk), .rst_n(rst_n),
    .net_irq_en(net_irq_en), .tx_force(tx_force), .rx_force(rx_force),
    .mask_match_en(mask_match_en), .own_accept(own_accept), .own_irq(own_irq),
    .filter_en(filter_en),
    .tx_valid(tx_valid), .tx_entry(tx_entry),
    .rx_valid(rx_valid), .rx_entry(rx_entry), .rx_irq(rx_irq),
    .rx_own(rx_own), .rx_same(rx_same),
    .tx_irq_flag(tx_irq_flag), .rx_mem_we(rx_mem_we), .rx_push(rx_push)
  );

  irq_addr_fifo #(.W(AW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(rx_push), .push_data(rx_addr),
    .pop_ready(irq_ready),
    .out_valid(irq_valid), .out_data(irq_addr),
    .drop(drop)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)         irq_overflow <= 1'b0;
    else if (drop)      irq_overflow <= 1'b1;
    else if (ovf_clear) irq_overflow <= 1'b0;
  end

  assign host_irq = irq_valid && net_irq_en;

  p_drop_sets_ovf_r8: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> irq_overflow);
  p_host_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq |-> irq_valid && net_irq_en);
endmodule

// File: tb/shmem_irq_ctrl_test.sv
module shmem_irq_ctrl_test;
  localparam int AW = 6;
  localparam int DEPTH = 16;

  logic clk = 0, rst_n = 0;
  logic net_irq_en = 0, tx_force = 0, rx_force = 0, mask_match_en = 0;
  logic own_accept = 0, own_irq = 0, filter_en = 0;
  logic acr_wr_en = 0; logic [AW-1:0] acr_wr_addr = '0; logic [1:0] acr_wr_data = '0;
  logic tx_valid = 0; logic [AW-1:0] tx_addr = '0; logic tx_irq_flag;
  logic rx_valid = 0; logic [AW-1:0] rx_addr = '0;
  logic rx_irq = 0, rx_own = 0, rx_same = 0, rx_mem_we;
  logic irq_valid, irq_ready = 0, irq_overflow, ovf_clear = 0, host_irq;
  logic [AW-1:0] irq_addr;

  int checks = 0, errors = 0, cycles = 0;

  always #2 clk = ~clk;

  shmem_irq_ctrl #(.AW(AW), .DEPTH(DEPTH)) uut (.*);

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic acr_write(input int a, input int d);
    acr_wr_en = 1; acr_wr_addr = AW'(a); acr_wr_data = 2'(d);
    tick();
    acr_wr_en = 0;
  endtask

  task automatic drain();
    irq_ready = 1;
    for (int i = 0; i < DEPTH + 2; i++) if (irq_valid) tick();
    irq_ready = 0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state
    chk(irq_valid == 0, "R6 reset empty", irq_valid, 0);
    chk(irq_addr == 0, "R7 reset zero addr", irq_addr, 0);
    chk(irq_overflow == 0, "R8 reset ovf", irq_overflow, 0);
    chk(host_irq == 0, "R9 reset host_irq", host_irq, 0);

    // R10: ACR cleared by reset - selected mode with no entry written gives nothing
    net_irq_en = 1; mask_match_en = 1;
    tx_valid = 1; tx_addr = 7; #1;
    chk(tx_irq_flag == 0, "R10 reset acr tx", tx_irq_flag, 0);
    tx_valid = 0;
    rx_valid = 1; rx_addr = 7; rx_irq = 1; tick(); rx_valid = 0;
    chk(irq_valid == 0, "R10 reset acr rx", irq_valid, 0);

    // R1 sweep: valid x enable x force x acr transmit bit
    for (int c = 0; c < 16; c++) begin
      int a; logic v, e, f, t, exp;
      v = c[3]; e = c[2]; f = c[1]; t = c[0];
      a = 8 + c;
      acr_write(a, {t, 1'b0});
      net_irq_en = e; tx_force = f; tx_valid = v; tx_addr = AW'(a); #1;
      exp = v && e && (f || t);
      chk(tx_irq_flag == exp, "R1 tx flag", tx_irq_flag, exp);
      @(negedge clk); tx_valid = 0;
    end
    tx_force = 0; net_irq_en = 1;

    // R2-R5 sweep over every receive control combination
    for (int c = 0; c < 512; c++) begin
      int a; logic rf, ar, mm, ri, ow, oa, oi, fe, sm, acc, push, we;
      rf = c[0]; ar = c[1]; mm = c[2]; ri = c[3]; ow = c[4];
      oa = c[5]; oi = c[6]; fe = c[7]; sm = c[8];
      a = 1 + (c % 60);
      acr_write(a, {1'b0, ar});
      rx_force = rf; mask_match_en = mm; own_accept = oa; own_irq = oi;
      filter_en = fe;
      rx_valid = 1; rx_addr = AW'(a); rx_irq = ri; rx_own = ow; rx_same = sm; #1;
      acc  = !ow || oa;
      push = acc && ri && (rf || ar) && mm && (!ow || oi);
      we   = acc && !(fe && sm && !ri);
      chk(rx_mem_we == we, "R4/R5 mem write", rx_mem_we, we);
      tick(); rx_valid = 0;
      if (ow) chk(irq_valid == push, "R4 own push", irq_valid, push);
      else if (!ri || !mm) chk(irq_valid == push, "R3 push gate", irq_valid, push);
      else chk(irq_valid == push, "R2 eligibility", irq_valid, push);
      if (push) chk(irq_addr == AW'(a), "R6 pushed addr", irq_addr, a);
      drain();
    end

    // FIFO order, fill, overflow
    rx_force = 1; mask_match_en = 1; filter_en = 0; rx_own = 0; rx_irq = 1; own_accept = 0;
    for (int i = 0; i < DEPTH; i++) begin
      rx_valid = 1; rx_addr = AW'(40 + i); tick();
    end
    rx_valid = 0;
    chk(irq_valid == 1, "R6 full valid", irq_valid, 1);
    chk(irq_overflow == 0, "R8 no ovf at full", irq_overflow, 0);
    chk(host_irq == 1, "R9 host irq", host_irq, 1);
    net_irq_en = 0; #1;
    chk(host_irq == 0, "R9 host irq gated", host_irq, 0);
    net_irq_en = 1;
    // push and pop together while full: kept, no overflow
    rx_valid = 1; rx_addr = 5; irq_ready = 1; tick();
    rx_valid = 0; irq_ready = 0;
    chk(irq_overflow == 0, "R8 push+pop full", irq_overflow, 0);
    chk(irq_addr == 41, "R6 head after pop", irq_addr, 41);
    // push while full, no pop: dropped
    rx_valid = 1; rx_addr = 9; tick(); rx_valid = 0;
    chk(irq_overflow == 1, "R8 drop sets ovf", irq_overflow, 1);
    irq_ready = 1;
    for (int i = 0; i < DEPTH; i++) begin
      int e;
      e = (i < DEPTH - 1) ? 41 + i : 5;
      chk(irq_addr == AW'(e), "R6 order", irq_addr, e);
      tick();
    end
    chk(irq_valid == 0, "R8 drop not stored", irq_valid, 0);
    // pop while empty has no effect
    tick();
    chk(irq_addr == 0, "R7 empty reads 0", irq_addr, 0);
    irq_ready = 0;
    rx_valid = 1; rx_addr = 33; tick(); rx_valid = 0;
    chk(irq_addr == 33 && irq_valid, "R7 empty pop no effect", irq_addr, 33);
    drain();
    // overflow clear; still sticky until cleared
    chk(irq_overflow == 1, "R8 sticky", irq_overflow, 1);
    ovf_clear = 1; tick(); ovf_clear = 0;
    chk(irq_overflow == 0, "R8 clear", irq_overflow, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule